// File: doc/BRIEF.md
# Decimal Leading-Zero Digit Anticipator

This block works next to a decimal significand adder and predicts how many leading zero digits the adder's result will have. The count is then ready as soon as the sum or difference is, so no zero detection is needed after the adder. Both operands are aligned binary-coded decimal significands. Each operand arrives with its own leading-zero digit count, which travels with the significand in the decoded internal format. The block also takes an add or subtract select, the adder's carry indication and a flag that says the result will be rounded.

For addition, the count comes from the two operand counts and the carry. For subtraction, an array of per-digit decimal subtractors feeds an encoding stage, which finds the first digit position that can be nonzero. A correction step then moves that estimate down by at most one digit. The result is registered, with a strobe one cycle after the input strobe. A new operation is accepted on every cycle.

Top module: `decLza`

## Requirements
- R1: During and right after reset, `outValid` is 0 and `lzcOut` is 0.
- R2: `outValid` is high in the cycle after a cycle with `inValid` high, and low in the cycle after a cycle with `inValid` low. An operation is accepted on every cycle.
- R3: Addition (`isSub`=0) without `addCarry` gives the smaller of `lzcA` and `lzcB`. Two all-zero operands (both counts 16) give 16.
- R4: Addition with `addCarry`=1 gives one less than the smaller operand count, clamped at 0. `addCarry` is high when the exact sum has more significant digits than the longer operand.
- R5: When `willRound` is 1, the count is 0 in either mode.
- R6: Subtraction (`isSub`=1, magnitude of `opA` at least that of `opB`) gives the exact number of leading zero digits of `opA`-`opB`. Digit i is bits [4i+3:4i] and digit 15 is the most significant.
- R7: Subtraction gives an exact count when borrows collapse the leading digits, as in a 1 followed by a run of digits that borrow (for example 1000…0 minus 0999…9, which gives 15).
- R8: Subtraction of equal operands gives 16.
- R9: In subtraction, `addCarry` has no effect on the count.
- R10: In a cycle after `inValid` was low, `lzcOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| isSub | input | 1 | 1 = subtract opB from opA, 0 = add |
| willRound | input | 1 | Result will be rounded; forces count 0 |
| addCarry | input | 1 | Sum grew past the longer operand (addition only) |
| opA | input | 64 | First significand, 16 BCD digits |
| opB | input | 64 | Second significand, 16 BCD digits |
| lzcA | input | 5 | Leading zero digits of opA (0..16) |
| lzcB | input | 5 | Leading zero digits of opB (0..16) |
| outValid | output | 1 | Count valid strobe |
| lzcOut | output | 5 | Leading zero digit count of the result (0..16) |

## Verification
The only state is the valid flag and the count register. A fault in either one appears at the ports in the very next cycle, as a strobe out of step with its input or as a count that differs from the exact count of the reference. A faulty borrow chain or a faulty encoding stage shows up only for operand pairs whose difference has collapsing leading digits. For that reason, directed borrow-run patterns are mixed with the random traffic, and every clock is compared.

// File: rtl/decLzaPkg.sv
package decLzaPkg;
  typedef struct packed {
    logic load;     // capture a new count this cycle
    logic subSel;   // take the subtraction path
    logic zeroOut;  // rounded result: count forced to zero
  } lzaCtrl_t;
endpackage

// File: rtl/decLzaDigitSub.sv
module decLzaDigitSub (
  input  logic              borrowIn,
  input  logic [3:0]        aDigit,
  input  logic [3:0]        bDigit,
  output logic signed [4:0] rawDiff,
  output logic              borrowOut
);
  logic signed [5:0] full;

  always_comb begin
    rawDiff   = $signed({1'b0, aDigit}) - $signed({1'b0, bDigit});
    full      = $signed({2'b00, aDigit}) - $signed({2'b00, bDigit}) - $signed({5'd0, borrowIn});
    borrowOut = full[5];
  end
endmodule

// File: rtl/decLzaControl.sv
module decLzaControl
  import decLzaPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     isSub,
  input  logic     willRound,
  output lzaCtrl_t ctrl,
  output logic     outValid
);
  always_comb begin
    ctrl.load    = inValid;
    ctrl.subSel  = isSub;
    ctrl.zeroOut = willRound;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/decLzaDatapath.sv
module decLzaDatapath
  import decLzaPkg::*;
#(
  parameter int DIGITS = 16,
  localparam int CW = $clog2(DIGITS + 1),
  localparam int SW = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rstN,
  input  lzaCtrl_t      ctrl,
  input  logic          addCarry,
  input  logic [SW-1:0] opA,
  input  logic [SW-1:0] opB,
  input  logic [CW-1:0] lzcA,
  input  logic [CW-1:0] lzcB,
  output logic [CW-1:0] lzcOut
);
  localparam logic signed [4:0] NEG_NINE = -5'sd9;
  localparam logic signed [4:0] POS_ONE  = 5'sd1;

  // per-digit subtractor array with ripple borrow
  logic              borrow [DIGITS+1];
  logic signed [4:0] digDiff [DIGITS];

  assign borrow[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    decLzaDigitSub u_sub (
      .borrowIn (borrow[g]),
      .aDigit   (opA[4*g +: 4]),
      .bDigit   (opB[4*g +: 4]),
      .rawDiff  (digDiff[g]),
      .borrowOut(borrow[g+1])
    );
  end

  // encoding: indicator string of nonzero digit differences
  logic [DIGITS-1:0] nzInd;
  for (genvar g = 0; g < DIGITS; g++) begin : g_ind
    assign nzInd[g] = (digDiff[g] != 5'sd0);
  end

  // locate leading indicator, extend over a borrow run, pick correction
  logic [CW-1:0] subPrelim;
  logic          subCorr;
  logic          foundLead;
  logic          runOpen;
  logic [CW-1:0] subLzc;

  always_comb begin
    subPrelim = CW'(DIGITS);
    subCorr   = 1'b0;
    foundLead = 1'b0;
    runOpen   = 1'b0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (!foundLead) begin
        if (nzInd[i]) begin
          foundLead = 1'b1;
          subPrelim = CW'(DIGITS - 1 - i);
          runOpen   = (digDiff[i] == POS_ONE);
          subCorr   = runOpen && borrow[i];
        end
      end else if (runOpen) begin
        if (digDiff[i] == NEG_NINE) begin
          subPrelim = CW'(DIGITS - 1 - i);
          subCorr   = borrow[i];
        end else begin
          runOpen = 1'b0;
        end
      end
    end
    subLzc = subPrelim + CW'(subCorr);
  end

  // addition path from the carried operand counts
  logic [CW-1:0] minLzc;
  logic [CW-1:0] addLzc;

  always_comb begin
    minLzc = (lzcA < lzcB) ? lzcA : lzcB;
    addLzc = (addCarry && (minLzc != '0)) ? minLzc - CW'(1) : minLzc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lzcOut <= '0;
    else if (ctrl.load) lzcOut <= ctrl.zeroOut ? '0 : (ctrl.subSel ? subLzc : addLzc);
  end
endmodule

// File: rtl/decLza.sv
module decLza
  import decLzaPkg::*;
#(
  parameter int DIGITS = 16,
  localparam int CW = $clog2(DIGITS + 1),
  localparam int SW = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          isSub,
  input  logic          willRound,
  input  logic          addCarry,
  input  logic [SW-1:0] opA,
  input  logic [SW-1:0] opB,
  input  logic [CW-1:0] lzcA,
  input  logic [CW-1:0] lzcB,
  output logic          outValid,
  output logic [CW-1:0] lzcOut
);
  lzaCtrl_t ctrl;

  decLzaControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isSub    (isSub),
    .willRound(willRound),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  decLzaDatapath #(.DIGITS(DIGITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .addCarry(addCarry),
    .opA     (opA),
    .opB     (opB),
    .lzcA    (lzcA),
    .lzcB    (lzcB),
    .lzcOut  (lzcOut)
  );
endmodule

// File: rtl/decLzaChecker.sv
module decLzaChecker #(
  parameter int DIGITS = 16,
  localparam int CW = $clog2(DIGITS + 1),
  localparam int SW = 4 * DIGITS
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          isSub,
  input logic          willRound,
  input logic          addCarry,
  input logic [SW-1:0] opA,
  input logic [SW-1:0] opB,
  input logic [CW-1:0] lzcA,
  input logic [CW-1:0] lzcB,
  input logic          outValid,
  input logic [CW-1:0] lzcOut
);
  logic [CW-1:0] smaller;
  assign smaller = (lzcA < lzcB) ? lzcA : lzcB;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r3_add_minimum: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !isSub && !willRound && !addCarry |=> lzcOut == $past(smaller));
  a_r4_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !isSub && !willRound && addCarry && smaller != '0 |=> lzcOut == $past(smaller) - CW'(1));
  a_r5_round_zero: assert property (@(posedge clk) disable iff (!rstN)
    inValid && willRound |=> lzcOut == '0);
  a_r8_sub_equal: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isSub && !willRound && opA == opB |=> lzcOut == CW'(DIGITS));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(lzcOut));
  a_r6_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> lzcOut <= CW'(DIGITS));
endmodule

bind decLza decLzaChecker #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .isSub(isSub),
  .willRound(willRound), .addCarry(addCarry), .opA(opA), .opB(opB),
  .lzcA(lzcA), .lzcB(lzcB), .outValid(outValid), .lzcOut(lzcOut)
);

// File: tb/decLza_tb.sv
module decLza_tb;
  localparam int DIGITS = 16;
  localparam int CW = 5;
  localparam int SW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0, isSub = 1'b0, willRound = 1'b0, addCarry = 1'b0;
  logic [SW-1:0] opA = '0, opB = '0;
  logic [CW-1:0] lzcA = '0, lzcB = '0;
  logic          outValid;
  logic [CW-1:0] lzcOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expectation for the next sampled cycle
  bit      pendValid = 0;
  int      pendLzc = 0;
  string   pendTag = "R1";
  int      heldLzc = 0;

  always #5 clk = ~clk;

  decLza #(.DIGITS(DIGITS)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isSub(isSub),
    .willRound(willRound), .addCarry(addCarry), .opA(opA), .opB(opB),
    .lzcA(lzcA), .lzcB(lzcB), .outValid(outValid), .lzcOut(lzcOut)
  );

  function automatic longint unsigned bcdVal(logic [SW-1:0] v);
    longint unsigned r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic int lzOf(longint unsigned v);
    longint unsigned p = 64'd1000000000000000;
    int n = 0;
    if (v == 0) return DIGITS;
    if (v >= 64'd10000000000000000) return 0;
    while (v < p) begin n++; p = p / 10; end
    return n;
  endfunction

  function automatic logic [SW-1:0] makeBcd(int lz);
    logic [SW-1:0] r = '0;
    for (int i = 0; i < DIGITS - lz; i++) begin
      if (i == DIGITS - lz - 1) r[4*i +: 4] = 4'(1 + $urandom_range(8));
      else                      r[4*i +: 4] = 4'($urandom_range(9));
    end
    return r;
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare outputs, then drive one cycle of stimulus
  task automatic step(bit v, bit sub, bit rnd, bit cfor, logic [SW-1:0] a, logic [SW-1:0] b, string tag);
    longint unsigned va, vb;
    logic [SW-1:0] t;
    int la, lb, mn, exp;
    bit c;
    @(negedge clk);
    check(outValid == pendValid, "R2", int'(outValid), int'(pendValid));
    if (pendValid) check(int'(lzcOut) == pendLzc, pendTag, int'(lzcOut), pendLzc);
    else           check(int'(lzcOut) == heldLzc, "R10", int'(lzcOut), heldLzc);
    if (pendValid) heldLzc = pendLzc;
    va = bcdVal(a); vb = bcdVal(b);
    if (sub && va < vb) begin t = a; a = b; b = t; va = bcdVal(a); vb = bcdVal(b); end
    la = lzOf(va); lb = lzOf(vb);
    mn = (la < lb) ? la : lb;
    if (sub) begin
      exp = lzOf(va - vb);
      c = cfor;
    end else begin
      exp = lzOf(va + vb);
      c = (exp < mn) || (va + vb >= 64'd10000000000000000);
    end
    if (rnd) begin exp = 0; tag = "R5"; end
    inValid = v; isSub = sub; willRound = rnd; addCarry = c;
    opA = a; opB = b; lzcA = CW'(la); lzcB = CW'(lb);
    pendValid = v; pendLzc = exp; pendTag = tag;
  endtask

  initial begin
    logic [SW-1:0] x, y;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(lzcOut == '0, "R1", int'(lzcOut), 0);

    // additions
    step(1, 0, 0, 0, '0, '0, "R3");
    step(1, 0, 0, 0, makeBcd(5), makeBcd(9), "R3");
    step(1, 0, 0, 0, {16{4'h9}}, 64'h1, "R4");
    step(1, 0, 0, 0, 64'h0000_0000_0000_0950, 64'h0000_0000_0000_0060, "R4");
    step(1, 0, 0, 0, 64'h0000_0000_0000_0001, '0, "R3");
    step(1, 0, 1, 0, makeBcd(4), makeBcd(7), "R5");
    // subtractions
    step(1, 1, 0, 0, 64'h1000_0000_0000_0000, 64'h0999_9999_9999_9999, "R7");
    step(1, 1, 0, 1, 64'h0000_0000_0100_0000, 64'h0000_0000_0099_9999, "R7");
    step(1, 1, 0, 0, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0998, "R7");
    step(1, 1, 0, 0, 64'h0000_2000_0000_0000, 64'h0000_1999_9999_9999, "R7");
    step(1, 1, 0, 0, 64'h0000_0000_0010_0005, 64'h0000_0000_0009_9997, "R7");
    x = makeBcd(3);
    step(1, 1, 0, 1, x, x, "R8");
    step(1, 1, 0, 1, 64'h0000_0000_0005_0000, 64'h0000_0000_0001_2345, "R9");
    step(1, 1, 1, 0, 64'h0000_0000_0005_0000, 64'h0000_0000_0001_2345, "R5");
    step(0, 1, 0, 0, makeBcd(2), makeBcd(2), "R10");
    step(0, 0, 0, 0, '0, '0, "R10");

    for (int n = 0; n < 3000; n++) begin
      bit sub = $urandom_range(1);
      bit cf = $urandom_range(1);
      int la = $urandom_range(16);
      int lb = (($urandom_range(3)) == 0) ? la : $urandom_range(16);
      x = makeBcd(la);
      y = makeBcd(lb);
      if (sub && $urandom_range(3) == 0) begin
        // borrow-run pattern: shared prefix, then 1 over 0 followed by 0 over 9
        int p = $urandom_range(DIGITS - 1);
        y = x;
        x[4*p +: 4] = 4'(1 + $urandom_range(8));
        y[4*p +: 4] = x[4*p +: 4] - 4'd1;
        for (int q = 0; q < p; q++) begin
          if ($urandom_range(4) != 0) begin x[4*q +: 4] = 4'd0; y[4*q +: 4] = 4'd9; end
        end
      end
      step($urandom_range(7) != 0, sub, $urandom_range(15) == 0, cf, x, y,
           sub ? (cf ? "R9" : "R6") : "R3");
    end
    step(0, 0, 0, 0, '0, '0, "R10");
    step(0, 0, 0, 0, '0, '0, "R10");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule